// File: doc/BRIEF.md
# Floating-Point Conditional Move Unit

This block carries out a family of eight conditional register moves on an eight-entry floating-point register stack. Each operation names one stack register, ST(i), as the source. The destination is always the stack top, ST(0). The block receives a two-byte opcode with an issue strobe and a lock-prefix indicator. It also takes three integer status flags (carry, zero, parity) and two control bits: emulation and task-switched. It decodes a condition from the opcode, screens the operation for faults in a fixed priority order, and then copies the source into the destination only when the condition holds. The integer flags are inputs only and are never written.

The stack storage is part of the block. It holds 80-bit values with one tag bit per entry (1 = valid, 0 = empty) and a 3-bit TOP pointer. The rest of the floating-point datapath fills and inspects the stack through a physical load port and a physical read port. Each operation finishes in one clock. A registered done pulse comes with the move, fault, condition-code and foreign-opcode indications.

Top module: `fcmov_unit`

## Requirements
- R1: After reset, TOP is 0, every tag is 0 (empty), every entry reads 0, and done, moved, fault and foreign outputs are 0.
- R2: First byte 0xDA with second byte `11ccciii`, where ccc is 000, 001, 010 or 011, tests the following conditions. 000 is below (CF=1). 001 is equal (ZF=1). 010 is below-or-equal (CF=1 or ZF=1). 011 is unordered (PF=1). When the test is true and there is no fault, ST(0) takes the value of ST(i) and moved is 1.
- R3: First byte 0xDB uses the same ccc codes with each test inverted. 000 is CF=0. 001 is ZF=0. 010 is CF=0 and ZF=0. 011 is PF=0.
- R4: A false condition leaves ST(0) data and tag unchanged, gives moved=0, and raises no fault.
- R5: ST(i) is the physical entry (TOP+i) mod 8 and ST(0) is the entry at TOP. An operation never changes TOP.
- R6: A lock prefix on a recognised opcode gives fault code 1 (invalid opcode) and no move.
- R7: When the emulation bit or the task-switched bit is 1, the result is fault code 2 (device not available) and no move.
- R8: If the tag of ST(0) or of ST(i) is empty, the result is fault code 3 (stack underflow), the C1-clear strobe, and no move. This holds whether the condition is true or false.
- R9: Only the highest-priority fault is reported. The order is code 1, then code 2, then code 3. fault_vld marks a nonzero code.
- R10: An issue is foreign when the first byte is not 0xDA/0xDB, the second byte's bits 7:6 are not 11, or ccc is 100..111. A foreign issue sets not_mine, reports no fault and changes no state, even with lock or control bits set.
- R11: done pulses for exactly one cycle, in the cycle after issue. A completed move leaves the destination tag valid.
- R12: The load port writes data and tag into the physical entry it names on the next edge. The read port returns the data and tag of a physical entry combinationally. A TOP write sets TOP on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation valid this cycle |
| op_b0_i | input | 8 | First opcode byte |
| op_b1_i | input | 8 | Second opcode byte |
| lock_i | input | 1 | Lock prefix present |
| flag_cf_i | input | 1 | Carry flag |
| flag_zf_i | input | 1 | Zero flag |
| flag_pf_i | input | 1 | Parity flag |
| cr_em_i | input | 1 | Emulation control bit |
| cr_ts_i | input | 1 | Task-switched control bit |
| ld_we_i | input | 1 | Load port write enable |
| ld_idx_i | input | 3 | Load port physical index |
| ld_data_i | input | 80 | Load port data |
| ld_tag_i | input | 1 | Load port tag (1 valid) |
| top_we_i | input | 1 | TOP write enable |
| top_val_i | input | 3 | New TOP value |
| rd_idx_i | input | 3 | Read port physical index |
| rd_data_o | output | 80 | Read port data |
| rd_tag_o | output | 1 | Read port tag |
| top_o | output | 3 | Current TOP |
| done_o | output | 1 | Operation complete pulse |
| moved_o | output | 1 | Move performed |
| not_mine_o | output | 1 | Issue was not a conditional move |
| fault_vld_o | output | 1 | A fault was reported |
| fault_code_o | output | 2 | 1 invalid opcode, 2 device not available, 3 stack underflow |
| c1_clear_o | output | 1 | C1 condition code cleared to 0 |

## Verification
Assertions check some behaviour on every cycle. A locked recognised issue always ends as fault 1, and a control-bit issue without lock always ends as fault 2. The C1-clear strobe appears only with an underflow fault. Foreign issues never move or fault, and every issue gives done on the next cycle. A move always puts the source value into ST(0) with a valid tag, and ST(0) and TOP hold when nothing writes them. Only the bench scenarios can show the full truth table of the eight conditions under all flag combinations, the modulo-8 wrap of the source address, underflow from each operand with the condition both true and false, and the way combined faults resolve to one code.

// File: rtl/fcmov_pkg.sv
package fcmov_pkg;
   localparam logic [7:0] OPC_TRUE_SENSE = 8'hDA;
   localparam logic [7:0] OPC_INV_SENSE  = 8'hDB;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_NM   = 2'd2,
      FLT_IS   = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      CC_BELOW = 2'd0,
      CC_EQUAL = 2'd1,
      CC_BE    = 2'd2,
      CC_UNORD = 2'd3
   } cond_e;

   typedef struct packed {
      logic       hit;
      logic       invert;
      cond_e      cond;
      logic [2:0] src_rel;
   } dec_s;
endpackage

// File: rtl/fcmov_decode.sv
module fcmov_decode
   import fcmov_pkg::*;
(
   input  logic [7:0] b0_i,
   input  logic [7:0] b1_i,
   output dec_s       dec_o
);
   logic b0_ok;
   logic b1_ok;

   always_comb begin
      b0_ok            = (b0_i == OPC_TRUE_SENSE) || (b0_i == OPC_INV_SENSE);
      b1_ok            = (b1_i[7:6] == 2'b11) && !b1_i[5];
      dec_o.hit        = b0_ok && b1_ok;
      dec_o.invert     = (b0_i == OPC_INV_SENSE);
      dec_o.cond       = cond_e'(b1_i[4:3]);
      dec_o.src_rel    = b1_i[2:0];
   end
endmodule

// File: rtl/fcmov_cond.sv
module fcmov_cond
   import fcmov_pkg::*;
#(
   parameter int EVAL_STYLE = 0
) (
   input  cond_e cond_i,
   input  logic  invert_i,
   input  logic  cf_i,
   input  logic  zf_i,
   input  logic  pf_i,
   output logic  take_o
);
   logic raw;

   generate
      if (EVAL_STYLE == 0) begin : g_mux
         always_comb begin
            case (cond_i)
               CC_BELOW: raw = cf_i;
               CC_EQUAL: raw = zf_i;
               CC_BE:    raw = cf_i | zf_i;
               default:  raw = pf_i;
            endcase
         end
      end else begin : g_sop
         assign raw = ((cond_i == CC_BELOW) & cf_i)
                    | ((cond_i == CC_EQUAL) & zf_i)
                    | ((cond_i == CC_BE)    & (cf_i | zf_i))
                    | ((cond_i == CC_UNORD) & pf_i);
      end
   endgenerate

   assign take_o = raw ^ invert_i;
endmodule

// File: rtl/fcmov_stack_rf.sv
module fcmov_stack_rf #(
   parameter  int DATA_W = 80,
   parameter  int DEPTH  = 8,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_we_i,
   input  logic [IDX_W-1:0]  ext_idx_i,
   input  logic [DATA_W-1:0] ext_data_i,
   input  logic              ext_tag_i,
   input  logic              top_we_i,
   input  logic [IDX_W-1:0]  top_val_i,
   input  logic              mv_we_i,
   input  logic [IDX_W-1:0]  src_rel_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [IDX_W-1:0]  top_o,
   output logic              st0_tag_o,
   output logic [DATA_W-1:0] st0_data_o,
   output logic              sti_tag_o,
   output logic [DATA_W-1:0] sti_data_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_tag_o
);
   logic [DATA_W-1:0] ent_data [DEPTH];
   logic [DEPTH-1:0]  ent_tag;
   logic [IDX_W-1:0]  top_q;
   logic [IDX_W-1:0]  src_phys;

   assign src_phys = top_q + src_rel_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        top_q <= '0;
      else if (top_we_i) top_q <= top_val_i;
   end

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic              hit_mv;
         logic              hit_ext;
         logic [DATA_W-1:0] val_q;
         logic              vld_q;

         assign hit_mv  = mv_we_i  && (top_q == IDX_W'(e));
         assign hit_ext = ext_we_i && (ext_idx_i == IDX_W'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               vld_q <= 1'b0;
            end else if (hit_mv) begin
               val_q <= sti_data_o;
               vld_q <= 1'b1;
            end else if (hit_ext) begin
               val_q <= ext_data_i;
               vld_q <= ext_tag_i;
            end
         end

         assign ent_data[e] = val_q;
         assign ent_tag[e]  = vld_q;
      end
   endgenerate

   assign top_o      = top_q;
   assign st0_data_o = ent_data[top_q];
   assign st0_tag_o  = ent_tag[top_q];
   assign sti_data_o = ent_data[src_phys];
   assign sti_tag_o  = ent_tag[src_phys];
   assign rd_data_o  = ent_data[rd_idx_i];
   assign rd_tag_o   = ent_tag[rd_idx_i];

   // R11: a move lands the source value in ST(0) with a valid tag
   assert_move_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mv_we_i && !top_we_i |=> st0_tag_o && (st0_data_o == $past(sti_data_o)));

   // R4: ST(0) holds when nothing writes the stack
   assert_st0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mv_we_i && !ext_we_i && !top_we_i |=> $stable(st0_data_o) && $stable(st0_tag_o));

   // R5: only the TOP write port moves TOP
   assert_top_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !top_we_i |=> $stable(top_o));
endmodule

// File: rtl/fcmov_unit.sv
module fcmov_unit
   import fcmov_pkg::*;
#(
   parameter  int DATA_W      = 80,
   parameter  int STACK_DEPTH = 8,
   parameter  int EVAL_STYLE  = 0,
   localparam int IDX_W       = $clog2(STACK_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [7:0]        op_b0_i,
   input  logic [7:0]        op_b1_i,
   input  logic              lock_i,
   input  logic              flag_cf_i,
   input  logic              flag_zf_i,
   input  logic              flag_pf_i,
   input  logic              cr_em_i,
   input  logic              cr_ts_i,
   input  logic              ld_we_i,
   input  logic [IDX_W-1:0]  ld_idx_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic              ld_tag_i,
   input  logic              top_we_i,
   input  logic [IDX_W-1:0]  top_val_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_tag_o,
   output logic [IDX_W-1:0]  top_o,
   output logic              done_o,
   output logic              moved_o,
   output logic              not_mine_o,
   output logic              fault_vld_o,
   output logic [1:0]        fault_code_o,
   output logic              c1_clear_o
);
   generate
      if (STACK_DEPTH != 8) begin : g_bad_depth
         $error("STACK_DEPTH must be 8: the opcode index field is 3 bits");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
      if (EVAL_STYLE < 0 || EVAL_STYLE > 1) begin : g_bad_style
         $error("EVAL_STYLE must be 0 or 1");
      end
   endgenerate

   dec_s              dec;
   logic              take;
   logic              st0_tag;
   logic              sti_tag;
   logic [DATA_W-1:0] st0_data;
   logic [DATA_W-1:0] sti_data;
   logic              ours;
   logic              foreign;
   logic              underflow;
   fault_e            flt;
   logic              mv_we;

   fcmov_decode u_dec (
      .b0_i  (op_b0_i),
      .b1_i  (op_b1_i),
      .dec_o (dec)
   );

   fcmov_cond #(.EVAL_STYLE(EVAL_STYLE)) u_cond (
      .cond_i   (dec.cond),
      .invert_i (dec.invert),
      .cf_i     (flag_cf_i),
      .zf_i     (flag_zf_i),
      .pf_i     (flag_pf_i),
      .take_o   (take)
   );

   fcmov_stack_rf #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_rf (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_we_i   (ld_we_i),
      .ext_idx_i  (ld_idx_i),
      .ext_data_i (ld_data_i),
      .ext_tag_i  (ld_tag_i),
      .top_we_i   (top_we_i),
      .top_val_i  (top_val_i),
      .mv_we_i    (mv_we),
      .src_rel_i  (dec.src_rel[IDX_W-1:0]),
      .rd_idx_i   (rd_idx_i),
      .top_o      (top_o),
      .st0_tag_o  (st0_tag),
      .st0_data_o (st0_data),
      .sti_tag_o  (sti_tag),
      .sti_data_o (sti_data),
      .rd_data_o  (rd_data_o),
      .rd_tag_o   (rd_tag_o)
   );

   // fixed fault order: invalid opcode, device not available, underflow
   always_comb begin
      ours      = issue_i && dec.hit;
      foreign   = issue_i && !dec.hit;
      underflow = !st0_tag || !sti_tag;
      if (!ours)                  flt = FLT_NONE;
      else if (lock_i)            flt = FLT_UD;
      else if (cr_em_i || cr_ts_i) flt = FLT_NM;
      else if (underflow)         flt = FLT_IS;
      else                        flt = FLT_NONE;
      mv_we = ours && (flt == FLT_NONE) && take;
   end

   logic       done_q, moved_q, nm_q, fv_q, c1_q;
   logic [1:0] fc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         moved_q <= 1'b0;
         nm_q    <= 1'b0;
         fv_q    <= 1'b0;
         fc_q    <= FLT_NONE;
         c1_q    <= 1'b0;
      end else begin
         done_q  <= issue_i;
         moved_q <= mv_we;
         nm_q    <= foreign;
         fv_q    <= (flt != FLT_NONE);
         fc_q    <= flt;
         c1_q    <= (flt == FLT_IS);
      end
   end

   assign done_o       = done_q;
   assign moved_o      = moved_q;
   assign not_mine_o   = nm_q;
   assign fault_vld_o  = fv_q;
   assign fault_code_o = fc_q;
   assign c1_clear_o   = c1_q;

   // R6: lock on a recognised opcode wins over every other fault
   assert_lock_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && dec.hit && lock_i |=> fault_vld_o && (fault_code_o == FLT_UD) && !moved_o);

   // R7, R9: control bits fault next when no lock
   assert_dev_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && dec.hit && !lock_i && (cr_em_i || cr_ts_i)
      |=> fault_vld_o && (fault_code_o == FLT_NM) && !moved_o);

   // R8: C1 clear only with the underflow fault, never with a move
   assert_c1_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      c1_clear_o |-> fault_vld_o && (fault_code_o == FLT_IS) && !moved_o);

   // R9: a reported fault carries a nonzero code and suppresses the move
   assert_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_vld_o |-> (fault_code_o != FLT_NONE) && !moved_o && !not_mine_o);

   // R10: a foreign issue neither moves nor faults
   assert_foreign_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      not_mine_o |-> done_o && !moved_o && !fault_vld_o && !c1_clear_o);

   // R11: every issue completes on the next cycle
   assert_done_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> done_o);
endmodule

// File: tb/fcmov_unit_tb_top.sv
module fcmov_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [7:0]  b0 = '0, b1 = '0;
   logic        lock = 1'b0, cf = 1'b0, zf = 1'b0, pf = 1'b0, em = 1'b0, ts = 1'b0;
   logic        ld_we = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [79:0] ld_data = '0;
   logic        ld_tag = 1'b0;
   logic        top_we = 1'b0;
   logic [2:0]  top_val = '0;
   logic [2:0]  rd_idx = '0;
   logic [79:0] rd_data;
   logic        rd_tag;
   logic [2:0]  top;
   logic        done, moved, not_mine, fault_vld, c1_clear;
   logic [1:0]  fault_code;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic r_done, r_moved, r_nm, r_fv, r_c1;
   logic [1:0] r_fc;

   always #4 clk = ~clk;

   fcmov_unit dut_i (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_b0_i(b0), .op_b1_i(b1),
      .lock_i(lock), .flag_cf_i(cf), .flag_zf_i(zf), .flag_pf_i(pf),
      .cr_em_i(em), .cr_ts_i(ts), .ld_we_i(ld_we), .ld_idx_i(ld_idx),
      .ld_data_i(ld_data), .ld_tag_i(ld_tag), .top_we_i(top_we), .top_val_i(top_val),
      .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_tag_o(rd_tag), .top_o(top),
      .done_o(done), .moved_o(moved), .not_mine_o(not_mine), .fault_vld_o(fault_vld),
      .fault_code_o(fault_code), .c1_clear_o(c1_clear)
   );

   function automatic logic [79:0] dv(input int k);
      return {16'h4000 + 16'(k), 64'hC0DE_0000_0000_0000 | 64'(k)};
   endfunction

   function automatic bit exp_take(input bit inv, input int c, input bit f_cf, f_zf, f_pf);
      bit t;
      case (c)
         0: t = f_cf;
         1: t = f_zf;
         2: t = f_cf | f_zf;
         default: t = f_pf;
      endcase
      return inv ? !t : t;
   endfunction

   task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ld(input int idx, input logic [79:0] d, input logic t);
      @(negedge clk);
      ld_we = 1'b1; ld_idx = 3'(idx); ld_data = d; ld_tag = t;
      @(posedge clk); #1;
      ld_we = 1'b0;
   endtask

   task automatic set_top(input int v);
      @(negedge clk);
      top_we = 1'b1; top_val = 3'(v);
      @(posedge clk); #1;
      top_we = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [79:0] d, output logic t);
      rd_idx = 3'(idx); #1;
      d = rd_data; t = rd_tag;
   endtask

   task automatic fill(input int t);
      set_top(t);
      for (int k = 0; k < 8; k++) ld(k, dv(k), 1'b1);
   endtask

   task automatic op(input logic [7:0] o0, input logic [7:0] o1, input bit lk,
                     input bit c, input bit z, input bit p, input bit e, input bit s);
      @(negedge clk);
      issue = 1'b1; b0 = o0; b1 = o1; lock = lk;
      cf = c; zf = z; pf = p; em = e; ts = s;
      @(posedge clk); #2;
      r_done = done; r_moved = moved; r_nm = not_mine;
      r_fv = fault_vld; r_fc = fault_code; r_c1 = c1_clear;
      issue = 1'b0; lock = 1'b0; em = 1'b0; ts = 1'b0;
   endtask

   task automatic t_reset();
      logic [79:0] d; logic t;
      chk("R1 top", 80'(top), 80'd0);
      chk("R1 done", 80'(done), 80'd0);
      chk("R1 fault_vld", 80'(fault_vld), 80'd0);
      for (int k = 0; k < 8; k++) begin
         rd(k, d, t);
         chk("R1 tag", 80'(t), 80'd0);
         chk("R1 data", d, 80'd0);
      end
   endtask

   task automatic t_load();
      logic [79:0] d; logic t;
      ld(5, 80'h1234_5678_9ABC_DEF0_1111, 1'b1);
      rd(5, d, t);
      chk("R12 load data", d, 80'h1234_5678_9ABC_DEF0_1111);
      chk("R12 load tag", 80'(t), 80'd1);
      ld(5, 80'h55, 1'b0);
      rd(5, d, t);
      chk("R12 reload data", d, 80'h55);
      chk("R12 reload tag", 80'(t), 80'd0);
      set_top(4);
      chk("R12 top write", 80'(top), 80'd4);
   endtask

   task automatic t_sense(input bit inv, input string req);
      logic [79:0] d; logic t; bit tk;
      fill(0);
      for (int c = 0; c < 4; c++) begin
         for (int f = 0; f < 8; f++) begin
            ld(0, dv(0), 1'b1);
            op(inv ? 8'hDB : 8'hDA, 8'(8'hC0 | (c << 3) | 3), 1'b0,
               f[0], f[1], f[2], 1'b0, 1'b0);
            tk = exp_take(inv, c, f[0], f[1], f[2]);
            rd(0, d, t);
            chk({req, " moved"}, 80'(r_moved), 80'(tk));
            chk({req, " st0"}, d, tk ? dv(3) : dv(0));
            chk({req, " no fault"}, 80'(r_fv), 80'd0);
         end
      end
   endtask

   task automatic t_false_hold();
      logic [79:0] d; logic t;
      fill(0);
      op(8'hDA, 8'hCA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      rd(0, d, t);
      chk("R4 done", 80'(r_done), 80'd1);
      chk("R4 moved", 80'(r_moved), 80'd0);
      chk("R4 st0 data", d, dv(0));
      chk("R4 st0 tag", 80'(t), 80'd1);
   endtask

   task automatic t_wrap();
      logic [79:0] d; logic t;
      fill(6);
      op(8'hDA, 8'hC5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      rd(6, d, t);
      chk("R5 dest at TOP gets (TOP+5)%8", d, dv(3));
      rd(3, d, t);
      chk("R5 source untouched", d, dv(3));
      rd(2, d, t);
      chk("R5 other entry untouched", d, dv(2));
      chk("R5 top unchanged", 80'(top), 80'd6);
   endtask

   task automatic t_lock();
      logic [79:0] d; logic t;
      fill(0);
      op(8'hDA, 8'hC9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      rd(0, d, t);
      chk("R6 fault_vld", 80'(r_fv), 80'd1);
      chk("R6 code", 80'(r_fc), 80'd1);
      chk("R6 no move", d, dv(0));
   endtask

   task automatic t_dev();
      logic [79:0] d; logic t;
      fill(0);
      op(8'hDB, 8'hC1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R7 em code", 80'(r_fc), 80'd2);
      chk("R7 em moved", 80'(r_moved), 80'd0);
      op(8'hDB, 8'hC1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R7 ts code", 80'(r_fc), 80'd2);
      rd(0, d, t);
      chk("R7 no move", d, dv(0));
   endtask

   task automatic t_under();
      logic [79:0] d; logic t;
      fill(0);
      ld(4, dv(44), 1'b0);
      op(8'hDA, 8'hC4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 src empty false cond code", 80'(r_fc), 80'd3);
      chk("R8 c1 clear", 80'(r_c1), 80'd1);
      op(8'hDA, 8'hC4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 src empty true cond moved", 80'(r_moved), 80'd0);
      rd(0, d, t);
      chk("R8 st0 kept", d, dv(0));
      ld(0, dv(9), 1'b0);
      op(8'hDA, 8'hC2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 dst empty code", 80'(r_fc), 80'd3);
      rd(0, d, t);
      chk("R8 dst tag stays empty", 80'(t), 80'd0);
      chk("R8 dst data kept", d, dv(9));
   endtask

   task automatic t_prio();
      fill(0);
      ld(1, dv(1), 1'b0);
      op(8'hDA, 8'hC1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R9 lock over all", 80'(r_fc), 80'd1);
      chk("R9 no c1 on lock", 80'(r_c1), 80'd0);
      op(8'hDA, 8'hC1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R9 device over underflow", 80'(r_fc), 80'd2);
      op(8'hDA, 8'hC1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R9 underflow alone", 80'(r_fc), 80'd3);
   endtask

   task automatic t_foreign();
      logic [79:0] d; logic t;
      fill(0);
      op(8'hDA, 8'hE1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R10 ccc=100 not_mine", 80'(r_nm), 80'd1);
      chk("R10 ccc=100 moved", 80'(r_moved), 80'd0);
      op(8'hDB, 8'hF9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R10 ccc=111 with lock no fault", 80'(r_fv), 80'd0);
      chk("R10 ccc=111 not_mine", 80'(r_nm), 80'd1);
      op(8'hD9, 8'hC1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R10 other first byte", 80'(r_nm), 80'd1);
      op(8'hDA, 8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R10 bits 7:6 not 11", 80'(r_nm), 80'd1);
      rd(0, d, t);
      chk("R10 st0 unchanged", d, dv(0));
      chk("R10 top unchanged", 80'(top), 80'd0);
   endtask

   task automatic t_done();
      logic [79:0] d; logic t;
      fill(2);
      op(8'hDB, 8'hD9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R11 done pulse", 80'(r_done), 80'd1);
      chk("R11 moved", 80'(r_moved), 80'd1);
      chk("R11 foreign flag low", 80'(r_nm), 80'd0);
      rd(2, d, t);
      chk("R11 dest tag valid", 80'(t), 80'd1);
      chk("R11 dest data", d, dv(3));
      @(posedge clk); #2;
      chk("R11 done single cycle", 80'(done), 80'd0);
      chk("R11 moved single cycle", 80'(moved), 80'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #2;
      t_reset();
      t_load();
      t_sense(1'b0, "R2");
      t_sense(1'b1, "R3");
      t_false_hold();
      t_wrap();
      t_lock();
      t_dev();
      t_under();
      t_prio();
      t_foreign();
      t_done();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule